// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the combinational steering logic for an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) whose register file has 16 entries, with register zero always reading as zero. Each cycle it compares the source register numbers of the instruction about to execute with the destination numbers held by the two older instructions downstream. From that comparison it chooses, for each ALU operand, whether the value comes from the register file or is bypassed from one of the later stages.

The block also protects the pipeline from two hazards. A load cannot hand over its data early enough for the instruction right behind it. When that instruction needs the loaded register, the block holds the fetch and decode stages for one cycle and injects an empty slot into execute. The loaded value then reaches the ALU one cycle later through the writeback bypass. Branches are predicted not taken and resolve in execute. A taken branch, or any jump including a register-indirect one, squashes the two younger instructions. The datapath uses the selects and strobes as they are produced, in the same cycle.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: An operand select reads 2'b10 (bypass from the memory-stage result) when the memory-stage instruction writes a register, that register is not zero, and it equals the operand's source number.
- R2: An operand select reads 2'b01 (bypass from the writeback-stage result) when the writeback-stage instruction writes a nonzero register equal to the operand's source number and the memory stage does not match under R1.
- R3: When both the memory and writeback stages match the same source under R1 and R2, the select reads 2'b10.
- R4: A destination of zero, or a cleared write enable, never causes a bypass. With no bypass the select reads 2'b00 (register file).
- R5: The selects for operand A (first source) and operand B (second source) are decided independently, so one operand may bypass from one stage while the other bypasses from another stage or not at all.
- R6: When the execute-stage instruction is a load whose nonzero destination equals either source of the decode-stage instruction, and no redirect is present, the outputs are pcWrite=0, ifIdWrite=0, ifIdFlush=0, idExBubble=1.
- R7: A match between the execute-stage destination and a decode-stage source does not stall when the execute-stage instruction is not a load.
- R8: A taken branch or a jump in execute gives pcWrite=1, ifIdWrite=1, ifIdFlush=1, idExBubble=1, which discards the two younger instructions.
- R9: When a redirect and a load-use condition occur in the same cycle, the redirect outputs of R8 are produced and no stall is raised.
- R10: With no hazard and no redirect, the outputs are pcWrite=1, ifIdWrite=1, ifIdFlush=0, idExBubble=0.
- R11: A load whose destination is register zero never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | 4 | First source register of the instruction in decode |
| idRs2 | input | 4 | Second source register of the instruction in decode |
| exRs1 | input | 4 | First source register of the instruction in execute (operand A) |
| exRs2 | input | 4 | Second source register of the instruction in execute (operand B) |
| exRd | input | 4 | Destination register of the instruction in execute |
| exRegWrite | input | 1 | Instruction in execute writes a register |
| exMemRead | input | 1 | Instruction in execute is a load |
| memRd | input | 4 | Destination register of the instruction in the memory stage |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | 4 | Destination register of the instruction in writeback |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| exBranchTaken | input | 1 | Branch in execute resolved taken |
| exJump | input | 1 | Jump (direct or register-indirect) in execute |
| fwdA | output | 2 | Operand A source select: 00 file, 10 memory stage, 01 writeback |
| fwdB | output | 2 | Operand B source select, same encoding |
| pcWrite | output | 1 | Program counter may update |
| ifIdWrite | output | 1 | Fetch/decode register may load |
| ifIdFlush | output | 1 | Fetch/decode register loads an empty slot |
| idExBubble | output | 1 | Decode/execute register loads an empty slot |

## Verification
The bench aims at the cases where both later stages name the same source register. A design with the priority reversed would bypass a stale writeback value. Destination zero with write enable set is covered, where a wrong design would bypass a value that should read as zero. Operands are mixed so that A and B take different paths, which exposes selects that are shared or swapped. On the hazard side the bench drives a load-use match on each source, a non-load match (which must not stall), a load to register zero, and a redirect in the same cycle as a load-use match. A design that let the stall win there would freeze the PC on a wrong-path instruction and lose the branch target. Long random sequences over a narrow register range then give dense collisions among all these conditions.

// File: rtl/hzfwd_pkg.sv
package hzfwd_pkg;

  // Operand source select: register file, writeback bypass, memory-stage bypass
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // Strobes handed from the control side to the pipeline registers
  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic ifIdFlush;
    logic idExBubble;
  } pipe_strobes_t;

endpackage

// File: rtl/hfc_operand_match.sv
module hfc_operand_match
  import hzfwd_pkg::*;
#(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 2
) (
  input  logic [REG_W-1:0] exSrc [NUM_SRC],
  input  logic [REG_W-1:0] idSrc [NUM_SRC],
  input  logic [REG_W-1:0] exRd,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  output fwd_sel_e         fwdSel [NUM_SRC],
  output logic             loadUseHit
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] luVec;

  // Stage-level qualifiers shared by every source comparator
  logic memLive, wbLive, loadLive;
  assign memLive  = memRegWrite && (memRd != ZERO_REG);
  assign wbLive   = wbRegWrite  && (wbRd  != ZERO_REG);
  assign loadLive = exMemRead   && (exRd  != ZERO_REG);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic memHit, wbHit;

    assign memHit   = memLive && (memRd == exSrc[s]);
    assign wbHit    = wbLive  && (wbRd  == exSrc[s]);
    assign luVec[s] = loadLive && (exRd == idSrc[s]);

    always_comb begin
      if (memHit)     fwdSel[s] = FWD_MEM;
      else if (wbHit) fwdSel[s] = FWD_WB;
      else            fwdSel[s] = FWD_RF;
    end

    // R4: register zero is never the target of a bypass
    always_comb begin
      a_r4_no_zero_fwd: assert (fwdSel[s] == FWD_RF || exSrc[s] != ZERO_REG)
        else $error("bypass selected for source register zero");
    end

    // R3: a live memory-stage match always wins over writeback
    always_comb begin
      a_r3_mem_priority: assert (!(memRegWrite && memRd != ZERO_REG &&
                                   memRd == exSrc[s]) || fwdSel[s] == FWD_MEM)
        else $error("memory-stage match did not take priority");
    end

    // R2: a writeback select needs a writing, matching writeback stage
    always_comb begin
      a_r2_wb_valid: assert (fwdSel[s] != FWD_WB ||
                             (wbRegWrite && wbRd == exSrc[s]))
        else $error("writeback select without a valid match");
    end
  end

  assign loadUseHit = |luVec;

endmodule

// File: rtl/hfc_stage_control.sv
module hfc_stage_control
  import hzfwd_pkg::*;
(
  input  logic          exBranchTaken,
  input  logic          exJump,
  input  logic          loadUseHit,
  output pipe_strobes_t strobes
);

  logic redirect;
  assign redirect = exBranchTaken || exJump;

  always_comb begin
    strobes = '{pcWrite: 1'b1, ifIdWrite: 1'b1, ifIdFlush: 1'b0, idExBubble: 1'b0};
    if (redirect) begin
      // squash the instructions in fetch and decode, take the new target
      strobes.ifIdFlush  = 1'b1;
      strobes.idExBubble = 1'b1;
    end else if (loadUseHit) begin
      // hold fetch and decode, send an empty slot into execute
      strobes.pcWrite    = 1'b0;
      strobes.ifIdWrite  = 1'b0;
      strobes.idExBubble = 1'b1;
    end
  end

  // R9: a redirect never freezes the front end
  always_comb begin
    a_r9_flush_over_stall: assert (!redirect || (strobes.pcWrite && strobes.ifIdWrite))
      else $error("redirect combined with a front-end hold");
  end

  // R6: a hold of the front end always comes with a bubble and no flush
  always_comb begin
    a_r6_stall_shape: assert (strobes.pcWrite ||
                              (strobes.idExBubble && !strobes.ifIdWrite && !strobes.ifIdFlush))
      else $error("malformed stall strobes");
  end

endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
  import hzfwd_pkg::*;
#(
  parameter  int REG_COUNT = 16,
  localparam int REG_W     = $clog2(REG_COUNT)
) (
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memRd,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbRegWrite,
  input  logic             exBranchTaken,
  input  logic             exJump,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             ifIdFlush,
  output logic             idExBubble
);

  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] exSrc [NUM_SRC];
  logic [REG_W-1:0] idSrc [NUM_SRC];
  fwd_sel_e         fwdSel [NUM_SRC];
  logic             loadUseHit;
  pipe_strobes_t    strobes;
  logic             unusedExWrite;

  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;
  assign idSrc[0] = idRs1;
  assign idSrc[1] = idRs2;
  // a load always writes; the write flag of execute adds nothing to the checks
  assign unusedExWrite = exRegWrite;

  hfc_operand_match #(
    .REG_W  (REG_W),
    .NUM_SRC(NUM_SRC)
  ) u_match (
    .exSrc      (exSrc),
    .idSrc      (idSrc),
    .exRd       (exRd),
    .exMemRead  (exMemRead),
    .memRd      (memRd),
    .memRegWrite(memRegWrite),
    .wbRd       (wbRd),
    .wbRegWrite (wbRegWrite),
    .fwdSel     (fwdSel),
    .loadUseHit (loadUseHit)
  );

  hfc_stage_control u_ctrl (
    .exBranchTaken(exBranchTaken),
    .exJump       (exJump),
    .loadUseHit   (loadUseHit),
    .strobes      (strobes)
  );

  assign fwdA       = fwdSel[0];
  assign fwdB       = fwdSel[1];
  assign pcWrite    = strobes.pcWrite;
  assign ifIdWrite  = strobes.ifIdWrite;
  assign ifIdFlush  = strobes.ifIdFlush;
  assign idExBubble = strobes.idExBubble;

  // R8: every flush of fetch/decode also empties the execute slot
  always_comb begin
    a_r8_flush_pair: assert (!ifIdFlush || idExBubble)
      else $error("flush without execute bubble");
  end

  // R11: a load to register zero leaves the front end running
  always_comb begin
    a_r11_zero_load: assert (!(exMemRead && exRd == '0) || pcWrite)
      else $error("stall on load to register zero");
  end

endmodule

// File: tb/hazard_fwd_ctrl_tb.sv
module hazard_fwd_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int N_RANDOM   = 3000;

  typedef struct {
    logic [3:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
    logic exRegWrite, exMemRead, memRegWrite, wbRegWrite, brTaken, jump;
  } stim_t;

  typedef struct {
    logic [1:0] fa, fb;
    logic pw, iw, fl, bb;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic exRegWrite, exMemRead, memRegWrite, wbRegWrite, exBranchTaken, exJump;
  logic [1:0] fwdA, fwdB;
  logic pcWrite, ifIdWrite, ifIdFlush, idExBubble;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;
  exp_t sbQueue[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_fwd_ctrl u_dut (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .exBranchTaken(exBranchTaken), .exJump(exJump),
    .fwdA(fwdA), .fwdB(fwdB), .pcWrite(pcWrite), .ifIdWrite(ifIdWrite),
    .ifIdFlush(ifIdFlush), .idExBubble(idExBubble)
  );

  // Reference model written from the requirements
  function automatic logic [1:0] refSel(logic [3:0] src, stim_t s);
    if (s.memRegWrite && s.memRd != 4'd0 && s.memRd == src) return 2'b10; // R1, R3
    if (s.wbRegWrite && s.wbRd != 4'd0 && s.wbRd == src) return 2'b01;    // R2
    return 2'b00;                                                          // R4
  endfunction

  function automatic exp_t refModel(stim_t s, string tag);
    exp_t e;
    logic lu;
    e.fa = refSel(s.exRs1, s);
    e.fb = refSel(s.exRs2, s);
    lu = s.exMemRead && s.exRd != 4'd0 && (s.exRd == s.idRs1 || s.exRd == s.idRs2);
    if (s.brTaken || s.jump) begin e.pw = 1; e.iw = 1; e.fl = 1; e.bb = 1; end // R8, R9
    else if (lu)             begin e.pw = 0; e.iw = 0; e.fl = 0; e.bb = 1; end // R6
    else                     begin e.pw = 1; e.iw = 1; e.fl = 0; e.bb = 0; end // R10
    e.tag = tag;
    return e;
  endfunction

  function automatic stim_t quiet();
    stim_t s;
    s.idRs1 = 0; s.idRs2 = 0; s.exRs1 = 0; s.exRs2 = 0; s.exRd = 0; s.memRd = 0; s.wbRd = 0;
    s.exRegWrite = 0; s.exMemRead = 0; s.memRegWrite = 0; s.wbRegWrite = 0;
    s.brTaken = 0; s.jump = 0;
    return s;
  endfunction

  // Driver: applies a stimulus after a rising edge and queues its expectation
  task automatic drive(stim_t s, string tag);
    @(posedge clk);
    idRs1 = s.idRs1; idRs2 = s.idRs2; exRs1 = s.exRs1; exRs2 = s.exRs2;
    exRd = s.exRd; memRd = s.memRd; wbRd = s.wbRd;
    exRegWrite = s.exRegWrite; exMemRead = s.exMemRead;
    memRegWrite = s.memRegWrite; wbRegWrite = s.wbRegWrite;
    exBranchTaken = s.brTaken; exJump = s.jump;
    sbQueue.push_back(refModel(s, tag));
  endtask

  // Monitor: samples on the falling edge and compares with the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      if (sbQueue.size() > 0) begin
        exp_t e;
        e = sbQueue.pop_front();
        nChecks++;
        if (fwdA !== e.fa || fwdB !== e.fb || pcWrite !== e.pw || ifIdWrite !== e.iw ||
            ifIdFlush !== e.fl || idExBubble !== e.bb) begin
          nBad++;
          $display("FAIL %s: actual fa=%b fb=%b pw=%b iw=%b fl=%b bb=%b expected fa=%b fb=%b pw=%b iw=%b fl=%b bb=%b",
                   e.tag, fwdA, fwdB, pcWrite, ifIdWrite, ifIdFlush, idExBubble,
                   e.fa, e.fb, e.pw, e.iw, e.fl, e.bb);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nBad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=completed");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    stim_t s;
    s = quiet();
    idRs1 = 0; idRs2 = 0; exRs1 = 0; exRs2 = 0; exRd = 0; memRd = 0; wbRd = 0;
    exRegWrite = 0; exMemRead = 0; memRegWrite = 0; wbRegWrite = 0;
    exBranchTaken = 0; exJump = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    drive(s, "R10 idle state");

    // R1: memory-stage bypass on operand A
    s = quiet(); s.exRs1 = 5; s.memRd = 5; s.memRegWrite = 1;
    drive(s, "R1 mem bypass A");
    // R1: memory-stage bypass on operand B
    s = quiet(); s.exRs2 = 9; s.memRd = 9; s.memRegWrite = 1;
    drive(s, "R1 mem bypass B");
    // R2: writeback bypass
    s = quiet(); s.exRs1 = 3; s.exRs2 = 3; s.wbRd = 3; s.wbRegWrite = 1;
    drive(s, "R2 wb bypass both");
    // R3: both stages match, memory wins
    s = quiet(); s.exRs1 = 7; s.exRs2 = 7; s.memRd = 7; s.wbRd = 7;
    s.memRegWrite = 1; s.wbRegWrite = 1;
    drive(s, "R3 mem over wb");
    // R3: memory matches with write disabled, writeback takes it
    s.memRegWrite = 0;
    drive(s, "R3 mem disabled falls to wb");
    // R4: destination zero with writes enabled
    s = quiet(); s.memRegWrite = 1; s.wbRegWrite = 1;
    drive(s, "R4 zero destination");
    // R4: matching numbers, no write enables
    s = quiet(); s.exRs1 = 12; s.memRd = 12; s.wbRd = 12;
    drive(s, "R4 no write enable");
    // R5: A from memory, B from writeback
    s = quiet(); s.exRs1 = 4; s.exRs2 = 6; s.memRd = 4; s.wbRd = 6;
    s.memRegWrite = 1; s.wbRegWrite = 1;
    drive(s, "R5 split operands");
    // R5: A from writeback, B from memory
    s = quiet(); s.exRs1 = 6; s.exRs2 = 4; s.memRd = 4; s.wbRd = 6;
    s.memRegWrite = 1; s.wbRegWrite = 1;
    drive(s, "R5 swapped operands");
    // R6: load-use on first and second decode source
    s = quiet(); s.exMemRead = 1; s.exRegWrite = 1; s.exRd = 8; s.idRs1 = 8;
    drive(s, "R6 load-use rs1");
    s = quiet(); s.exMemRead = 1; s.exRegWrite = 1; s.exRd = 15; s.idRs2 = 15; s.idRs1 = 2;
    drive(s, "R6 load-use rs2");
    // R7: ALU result match in execute, no stall
    s = quiet(); s.exRegWrite = 1; s.exRd = 8; s.idRs1 = 8; s.idRs2 = 8;
    drive(s, "R7 non-load no stall");
    // R11: load into register zero
    s = quiet(); s.exMemRead = 1; s.exRegWrite = 1; s.exRd = 0;
    drive(s, "R11 load to zero");
    // R8: taken branch, then jump
    s = quiet(); s.brTaken = 1;
    drive(s, "R8 taken branch");
    s = quiet(); s.jump = 1; s.exRs1 = 2; s.wbRd = 2; s.wbRegWrite = 1;
    drive(s, "R8 jump");
    // R9: redirect and load-use together
    s = quiet(); s.brTaken = 1; s.exMemRead = 1; s.exRegWrite = 1; s.exRd = 10; s.idRs1 = 10;
    drive(s, "R9 flush beats stall");
    s.brTaken = 0; s.jump = 1;
    drive(s, "R9 jump beats stall");

    // Dense random traffic over a narrow register range
    for (int i = 0; i < N_RANDOM; i++) begin
      exp_t peek;
      s.idRs1 = 4'($urandom_range(0, 3)); s.idRs2 = 4'($urandom_range(0, 3));
      s.exRs1 = 4'($urandom_range(0, 3)); s.exRs2 = 4'($urandom_range(0, 3));
      s.exRd  = 4'($urandom_range(0, 3)); s.memRd = 4'($urandom_range(0, 3));
      s.wbRd  = 4'($urandom_range(0, 3));
      s.exMemRead = 1'($urandom_range(0, 1)); s.exRegWrite = s.exMemRead | 1'($urandom_range(0, 1));
      s.memRegWrite = 1'($urandom_range(0, 1)); s.wbRegWrite = 1'($urandom_range(0, 1));
      s.brTaken = ($urandom_range(0, 7) == 0); s.jump = ($urandom_range(0, 11) == 0);
      peek = refModel(s, "");
      if (peek.fl)                 drive(s, "R8 random redirect");
      else if (peek.bb)            drive(s, "R6 random stall");
      else if (peek.fa | peek.fb)  drive(s, "R1 random bypass");
      else                         drive(s, "R10 random quiet");
    end

    wait (sbQueue.size() == 0);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule